// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits on the host side of a PCI bridge. It keeps a configuration address register that software loads through a simple write port. Each later access to the configuration data window is checked against that register. The block then decides whether a bus cycle is needed and, if so, which kind. In the same clock it supplies the 32-bit word the bridge drives on the AD lines during the address phase. The byte lanes of the access travel with it.

Accesses to the local bus (bus number zero) become type 0 cycles. In a type 0 cycle the device number is turned into a single IDSEL line on AD31..AD11. Accesses to any other bus become type 1 cycles, which carry the bus, device, function and register fields unchanged. Device number 31 never produces a configuration cycle. It is diverted to a special cycle on a write and to an interrupt-acknowledge cycle on a read.

When no cycle is issued, the block answers reads itself with a fixed value. This happens when the register is disabled, or when a local device number has no IDSEL line. Writes in those cases are dropped.

Top module: `cfg_addr_xlate`

## Requirements
- R1: The address register is loaded from `cfg_wdata` on a clock edge with `cfg_wr` high. It keeps its value until the next such write. Data-window accesses never change it. The register fields are: enable bit 31, bus 23:16, device 15:11, function 10:8, register 7:2.
- R2: `cyc_req` is high only in a clock where `win_stb` is high and a cycle qualifies. Without a request, `cyc_kind` is 0 (none), and `cyc_we` and `cyc_addr` are zero.
- R3: With enable set and device below 31, bus 0 gives `cyc_kind` = 1 (type 0) and any other bus gives `cyc_kind` = 2 (type 1).
- R4: In a type 0 cycle with device n from 11 to 30, AD[n] is the only bit of AD31..AD11 that is high.
- R5: In a type 0 cycle with device 10, AD31 is high and AD30..AD11 are low.
- R6: In a type 0 cycle, AD10..AD2 carry the function and register fields unchanged, and AD1..AD0 are 00.
- R7: In a type 1 cycle, AD23..AD2 carry the bus, device, function and register fields in their register positions. AD1..AD0 are 01 and AD31..AD24 are zero.
- R8: With enable set and device 31, on any bus, a request is raised with `cyc_kind` = 3 and `cyc_addr` zero. `cyc_we` is 1 for a write (special cycle) and 0 for a read (interrupt acknowledge).
- R9: During a request, `cyc_be` equals `win_be` and `cyc_we` equals `win_we`. Without a request, `cyc_be` is zero.
- R10: With enable clear, no request is raised. A window read sets `rsp_vld` with `rsp_data` = 0.
- R11: With enable set, bus 0 and device 0 to 9, no request is raised. A read sets `rsp_vld` with `rsp_data` = all ones. A write raises neither a request nor a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the configuration address register |
| cfg_wdata | input | 32 | Value for the configuration address register |
| win_stb | input | 1 | Data-window access in this clock |
| win_we | input | 1 | Access is a write (1) or read (0) |
| win_be | input | 4 | Byte lanes of the access |
| cyc_req | output | 1 | Bus cycle requested this clock |
| cyc_kind | output | 2 | 0 none, 1 type 0, 2 type 1, 3 special/interrupt-acknowledge |
| cyc_we | output | 1 | Requested cycle is a write |
| cyc_addr | output | 32 | Address-phase word for AD31..AD0 |
| cyc_be | output | 4 | Byte enables of the requested cycle |
| rsp_vld | output | 1 | Read answered locally this clock |
| rsp_data | output | 32 | Locally supplied read data |

## Verification
Some properties are checked by assertions on every cycle:
- the register holds its value between writes;
- a request needs a strobe, and idle outputs are zero;
- a type 0 word has exactly one IDSEL bit and low bits 00;
- a type 1 word has a zero top byte and low bits 01;
- byte enables are gated off when there is no request;
- a local answer never coincides with a request.

The bench's scenarios are what show the rest: which IDSEL bit each device number selects, including the wrap of device 10 to AD31; that the fields land in the right positions; the redirection of device 31 by direction; and the exact fill values for disabled and unmapped reads.

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  input  logic        win_stb,
  input  logic        win_we,
  input  logic [3:0]  win_be,
  output logic        cyc_req,
  output logic [1:0]  cyc_kind,
  output logic        cyc_we,
  output logic [31:0] cyc_addr,
  output logic [3:0]  cyc_be,
  output logic        rsp_vld,
  output logic [31:0] rsp_data
);
  localparam logic [1:0] K_NONE = 2'd0, K_T0 = 2'd1, K_T1 = 2'd2, K_SPC = 2'd3;

  logic       en;
  logic [7:0] bus;
  logic [4:0] dev;
  logic [2:0] fn;
  logic [5:0] rg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 1'b0; bus <= '0; dev <= '0; fn <= '0; rg <= '0;
    end else if (cfg_wr) begin
      en  <= cfg_wdata[31];
      bus <= cfg_wdata[23:16];
      dev <= cfg_wdata[15:11];
      fn  <= cfg_wdata[10:8];
      rg  <= cfg_wdata[7:2];
    end

  wire local_bus = (bus == 8'd0);
  wire special   = (dev == 5'd31);
  wire no_idsel  = local_bus && (dev < 5'd10);

  logic [1:0] kind;
  always_comb
    if (!en || no_idsel) kind = K_NONE;
    else if (special)    kind = K_SPC;
    else if (local_bus)  kind = K_T0;
    else                 kind = K_T1;

  logic [20:0] idsel;
  always_comb begin
    idsel = '0;
    if (dev == 5'd10)                       idsel[20] = 1'b1;
    else if (dev >= 5'd11 && dev <= 5'd30)  idsel = 21'd1 << (dev - 5'd11);
  end

  wire [31:0] t0_word = {idsel, fn, rg, 2'b00};
  wire [31:0] t1_word = {8'h00, bus, dev, fn, rg, 2'b01};

  assign cyc_req  = win_stb && (kind != K_NONE);
  assign cyc_kind = cyc_req ? kind : K_NONE;
  assign cyc_we   = cyc_req && win_we;
  assign cyc_be   = cyc_req ? win_be : 4'h0;
  assign cyc_addr = !cyc_req        ? 32'h0 :
                    (kind == K_T0)  ? t0_word :
                    (kind == K_T1)  ? t1_word : 32'h0;

  assign rsp_vld  = win_stb && !win_we && !cyc_req;
  assign rsp_data = (rsp_vld && en) ? 32'hFFFF_FFFF : 32'h0;

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable({en, bus, dev, fn, rg}));

  assert_req_needs_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |-> win_stb);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_req |-> (cyc_kind == K_NONE && !cyc_we && cyc_addr == 32'h0));

  assert_t0_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == K_T0) |-> $onehot(cyc_addr[31:11]));

  assert_t0_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == K_T0) |-> (cyc_addr[1:0] == 2'b00));

  assert_t1_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == K_T1) |-> (cyc_addr[1:0] == 2'b01 && cyc_addr[31:24] == 8'h00));

  assert_be_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_req |-> (cyc_be == 4'h0));

  assert_off_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !cyc_req);

  assert_rsp_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> !cyc_req);
endmodule

// File: tb/cfg_addr_xlate_tb.sv
module cfg_addr_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        win_stb = 1'b0;
  logic        win_we = 1'b0;
  logic [3:0]  win_be = '0;
  logic        cyc_req, cyc_we, rsp_vld;
  logic [1:0]  cyc_kind;
  logic [31:0] cyc_addr, rsp_data;
  logic [3:0]  cyc_be;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;
  logic [31:0] m_cfg = '0;

  always #10 clk = ~clk;

  cfg_addr_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .win_stb(win_stb), .win_we(win_we), .win_be(win_be),
    .cyc_req(cyc_req), .cyc_kind(cyc_kind), .cyc_we(cyc_we),
    .cyc_addr(cyc_addr), .cyc_be(cyc_be), .rsp_vld(rsp_vld), .rsp_data(rsp_data)
  );

  task automatic compare(input string tag);
    logic        e_req, e_we, e_rv;
    logic [1:0]  e_kind;
    logic [31:0] e_addr, e_rd;
    logic [3:0]  e_be;
    int          d;
    e_req = 0; e_we = 0; e_rv = 0; e_kind = 0; e_addr = 0; e_rd = 0; e_be = 0;
    d = int'(m_cfg[15:11]);
    if (win_stb) begin
      if (!m_cfg[31]) begin
        e_rv = !win_we;
      end else if (d == 31) begin
        e_req = 1; e_kind = 3;
      end else if (m_cfg[23:16] != 0) begin
        e_req = 1; e_kind = 2; e_addr = (m_cfg & 32'h00FF_FFFC) | 32'h1;
      end else if (d < 10) begin
        e_rv = !win_we; e_rd = e_rv ? 32'hFFFF_FFFF : 32'h0;
      end else begin
        e_req = 1; e_kind = 1;
        e_addr = ((d == 10) ? 32'h8000_0000 : (32'h1 << d)) | (m_cfg & 32'h0000_07FC);
      end
      if (e_req) begin e_we = win_we; e_be = win_be; end
    end
    vectors++;
    if ({cyc_req, cyc_kind, cyc_we, cyc_addr, cyc_be, rsp_vld, rsp_data} !==
        {e_req, e_kind, e_we, e_addr, e_be, e_rv, e_rd}) begin
      misses++;
      $display("FAIL %s cfg=%h req/kind/we=%b/%0d/%b addr=%h be=%h rsp=%b/%h expected %b/%0d/%b addr=%h be=%h rsp=%b/%h",
               tag, m_cfg, cyc_req, cyc_kind, cyc_we, cyc_addr, cyc_be, rsp_vld, rsp_data,
               e_req, e_kind, e_we, e_addr, e_be, e_rv, e_rd);
    end
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1; cfg_wdata = v;
    #5 compare("R2 idle during write");
    @(posedge clk);
    m_cfg = v & 32'h80FF_FFFC;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic access(input logic we, input logic [3:0] be, input string tag);
    @(negedge clk);
    win_stb = 1; win_we = we; win_be = be;
    #5 compare(tag);
    @(negedge clk);
    win_stb = 0; win_we = 0; win_be = 0;
    #5 compare("R2 idle after access");
  endtask

  function automatic logic [31:0] mk(input logic e, input int b, input int d, input int f, input int r);
    return {e, 7'h0, 8'(b), 5'(d), 3'(f), 6'(r), 2'b00};
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    #5 compare("R2 reset state");
    rst_n = 1;
    access(0, 4'hF, "R10 read after reset");
    load(mk(1, 0, 11, 2, 5));
    access(0, 4'hF, "R4 dev 11");
    for (int d = 0; d < 32; d++) begin
      load(mk(1, 0, d, d % 8, (d * 3) % 64));
      if (d == 10)      access(0, 4'hF, "R5 dev 10 wraps to AD31");
      else if (d == 31) access(0, 4'hF, "R8 interrupt acknowledge");
      else if (d < 10)  access(0, 4'hF, "R11 unmapped read");
      else              access(0, 4'h3, "R4 R6 type 0 idsel and fields");
    end
    load(mk(1, 0, 3, 1, 1));
    access(1, 4'hF, "R11 unmapped write dropped");
    load(mk(1, 0, 20, 7, 63));
    access(1, 4'h1, "R9 one byte lane");
    access(1, 4'h6, "R9 two byte lanes");
    access(0, 4'hE, "R9 three byte lanes");
    access(0, 4'hF, "R1 register held across accesses");
    load(mk(1, 1, 0, 0, 0));
    access(0, 4'hF, "R3 R7 type 1 bus 1");
    load(mk(1, 255, 31, 7, 63) | 32'h7F00_0003);
    access(1, 4'hF, "R8 special cycle on far bus");
    load(mk(1, 8'hA5, 17, 5, 42) | 32'h7F00_0003);
    access(1, 4'hC, "R7 type 1 reserved bits ignored");
    access(0, 4'hF, "R3 type 1 read");
    load(mk(0, 0, 15, 1, 2));
    access(0, 4'hF, "R10 disabled read");
    access(1, 4'hF, "R10 disabled write");
    load(mk(1, 0, 30, 0, 0));
    access(0, 4'hF, "R1 R4 dev 30 after reload");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        misses++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule